// File: doc/BRIEF.md
# Dual Decode Slot Microcode Steering

This block sits between an instruction queue and a pair of decode slots. Each cycle the queue presents up to two boundary-marked instructions, the older one in slot 0 and the younger one in slot 1. For each instruction the block receives four things: its byte length, its prefix count, a flag for floating-point stack (x87) operations and a flag for operations too complex to decode directly. From these it decides which slots go to the decoders in this cycle and whether the slot 0 instruction goes down the microcode sequencer path.

The queue uses the per-slot valid outputs to see how many head entries were taken. A set `dec_valid[0]` alone takes one entry, and both bits set take two. An instruction in slot 1 that is held moves to the head of the queue, so it is offered again in slot 0 on a later cycle and program order holds. Only slot 0 can start a microcode transfer. Each transfer keeps the block busy for a fixed number of extra cycles. During those cycles the queue is stalled and neither slot issues.

Top module: `dual_decode_steer`

## Requirements
- R1: After a synchronous active-low reset the block is idle: `q_stall` is 0, and in the first cycle after reset is released a pair of plain instructions issues on both slots. A reset during a microcode delay cancels that delay.
- R2: Two valid instructions that are both direct-decodable and not both x87 issue together: `dec_valid` = 2'b11, `ucode_req` = 0.
- R3: An instruction whose length exceeds 8 bytes needs microcode. A length of exactly 8 decodes directly.
- R4: An instruction with more than 3 prefixes needs microcode. Exactly 3 prefixes decodes directly.
- R5: An instruction with the complex flag set needs microcode, whatever its length and prefixes.
- R6: If slot 0 is direct and slot 1 needs microcode, only slot 0 issues (`dec_valid` = 2'b01) and `ucode_req` stays 0. The slot 1 instruction is left in the queue.
- R7: If slot 0 needs microcode, slot 0 issues with `ucode_req` = 1 and slot 1 is not issued. For the next 2 cycles `q_stall` = 1 and `dec_valid` = 0 whatever the inputs are. In the cycle after that the block accepts instructions again.
- R8: When both slots hold x87 instructions, only slot 0 issues in that cycle.
- R9: A valid slot 1 with an invalid slot 0 issues nothing.
- R10: `ucode_req` is asserted only together with `dec_valid[0]`, and never together with `dec_valid[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 2 | Per-slot instruction present; bit 0 is the older slot |
| s0_len | input | 4 | Slot 0 instruction length in bytes |
| s0_pfx | input | 3 | Slot 0 prefix count |
| s0_x87 | input | 1 | Slot 0 is an x87 instruction |
| s0_cplx | input | 1 | Slot 0 is a complex operation |
| s1_len | input | 4 | Slot 1 instruction length in bytes |
| s1_pfx | input | 3 | Slot 1 prefix count |
| s1_x87 | input | 1 | Slot 1 is an x87 instruction |
| s1_cplx | input | 1 | Slot 1 is a complex operation |
| dec_valid | output | 2 | Per-slot issue to the decoders; gives the number of queue entries taken |
| ucode_req | output | 1 | Slot 0 instruction goes to the microcode sequencer |
| q_stall | output | 1 | Queue must hold; the microcode delay is in progress |

## Verification
The bench probes the thresholds from both sides: length 8 against 9 and 3 prefixes against 4. A design with an off-by-one comparison would either send borderline instructions to microcode or let oversized ones through as a pair. It places each microcode trigger in slot 1 to confirm that slot 1 never raises a request and does not slip past the older instruction. It also drives full valid pairs during the delay window to catch a design that issues before the two-cycle delay has ended. Further cases cover x87 pairs, a slot 1 instruction with no slot 0 instruction ahead of it, and a reset that arrives during the delay, which a design that ignored reset for its delay count would not clear.

// File: rtl/dds_pkg.sv
// Shared widths and the per-instruction descriptor of the steering block.
package dds_pkg;
    localparam int LEN_W = 4;   // instruction length field width
    localparam int PFX_W = 3;   // prefix count field width
    localparam int NSLOT = 2;   // decode slots

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [PFX_W-1:0] pfx;
        logic             x87;
        logic             cplx;
    } instr_t;
endpackage

// File: rtl/dds_classify.sv
// Decides whether one instruction must take the microcode path.
// Assumes the length and prefix counts are already decoded by the marker logic.
module dds_classify
    import dds_pkg::*;
#(
    parameter int MAX_LEN = 8,
    parameter int MAX_PFX = 3
) (
    input  instr_t ins,
    output logic   needs_uc
);
    localparam int LEN_CMP_W = LEN_W + 1;
    localparam int PFX_CMP_W = PFX_W + 1;

    // Oversized, heavily prefixed or flagged-complex goes to microcode.
    always_comb begin
        needs_uc = ins.cplx
                 | (LEN_CMP_W'(ins.len) > LEN_CMP_W'(MAX_LEN))
                 | (PFX_CMP_W'(ins.pfx) > PFX_CMP_W'(MAX_PFX));
    end
endmodule

// File: rtl/dds_uc_timer.sv
// Counts the extra cycles of a microcode transfer and reports busy meanwhile.
// Assumes start is only pulsed while not busy.
module dds_uc_timer #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = (DELAY < 1) ? 1 : $clog2(DELAY + 1);

    logic [CW-1:0] cnt;

    // Load the delay on a transfer, then count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (start)       cnt <= CW'(DELAY);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    // Busy while any delay cycles remain.
    always_comb busy = (cnt != '0);

    a_r7_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DELAY));
endmodule

// File: rtl/dds_pair.sv
// Issue pairing: picks which slots go to the decoders this cycle.
// Assumes slot 0 is older than slot 1 and that a held slot 1 is re-presented in slot 0.
module dds_pair
    import dds_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] valid,
    input  logic [NSLOT-1:0] needs_uc,
    input  logic [NSLOT-1:0] x87,
    input  logic             busy,
    output logic [NSLOT-1:0] dec_valid,
    output logic             ucode_req
);
    logic head_go;
    logic pair_ok;

    // Slot 0 goes when present and no delay is running; slot 1 only beside a direct slot 0.
    always_comb begin
        head_go      = valid[0] & ~busy;
        pair_ok      = ~needs_uc[0] & valid[1] & ~needs_uc[1] & ~(x87[0] & x87[1]);
        dec_valid[0] = head_go;
        dec_valid[1] = head_go & pair_ok;
        ucode_req    = head_go & needs_uc[0];
    end

    a_r9_slot1_needs_head: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid[1] |-> dec_valid[0]);
    a_r6_slot1_direct_only: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid[1] |-> !needs_uc[1]);
    a_r8_one_x87: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid[1] |-> !(x87[0] && x87[1]));
    a_r10_uc_alone: assert property (@(posedge clk) disable iff (!rst_n)
        ucode_req |-> (dec_valid == 2'b01));
endmodule

// File: rtl/dual_decode_steer.sv
// Top of the steering block: classifies both slots, pairs them and runs the
// microcode delay. Assumes the queue pops as many head entries as dec_valid bits set.
module dual_decode_steer
    import dds_pkg::*;
#(
    parameter int MAX_LEN  = 8,
    parameter int MAX_PFX  = 3,
    parameter int UC_DELAY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       in_valid,
    input  logic [LEN_W-1:0] s0_len,
    input  logic [PFX_W-1:0] s0_pfx,
    input  logic             s0_x87,
    input  logic             s0_cplx,
    input  logic [LEN_W-1:0] s1_len,
    input  logic [PFX_W-1:0] s1_pfx,
    input  logic             s1_x87,
    input  logic             s1_cplx,
    output logic [1:0]       dec_valid,
    output logic             ucode_req,
    output logic             q_stall
);
    instr_t           slot [NSLOT];
    logic [NSLOT-1:0] uc_need;
    logic [NSLOT-1:0] x87_v;
    logic             busy;

    // Gather port fields into per-slot descriptors.
    always_comb begin
        slot[0] = '{len: s0_len, pfx: s0_pfx, x87: s0_x87, cplx: s0_cplx};
        slot[1] = '{len: s1_len, pfx: s1_pfx, x87: s1_x87, cplx: s1_cplx};
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        dds_classify #(.MAX_LEN(MAX_LEN), .MAX_PFX(MAX_PFX)) u_cls (
            .ins      (slot[g]),
            .needs_uc (uc_need[g])
        );
        assign x87_v[g] = slot[g].x87;
    end

    dds_pair u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (in_valid),
        .needs_uc  (uc_need),
        .x87       (x87_v),
        .busy      (busy),
        .dec_valid (dec_valid),
        .ucode_req (ucode_req)
    );

    dds_uc_timer #(.DELAY(UC_DELAY)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ucode_req),
        .busy  (busy)
    );

    // The queue holds exactly while the microcode delay runs.
    always_comb q_stall = busy;

    a_r7_stall_follows_uc: assert property (@(posedge clk) disable iff (!rst_n)
        ucode_req |=> q_stall);
    a_r7_quiet_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        q_stall |-> (dec_valid == 2'b00 && !ucode_req));
    a_r1_out_of_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !q_stall);
endmodule

// File: tb/tb_dual_decode_steer.sv
module tb_dual_decode_steer;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] in_valid;
    logic [3:0] s0_len, s1_len;
    logic [2:0] s0_pfx, s1_pfx;
    logic       s0_x87, s0_cplx, s1_x87, s1_cplx;
    logic [1:0] dec_valid;
    logic       ucode_req, q_stall;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    dual_decode_steer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .s0_len(s0_len), .s0_pfx(s0_pfx), .s0_x87(s0_x87), .s0_cplx(s0_cplx),
        .s1_len(s1_len), .s1_pfx(s1_pfx), .s1_x87(s1_x87), .s1_cplx(s1_cplx),
        .dec_valid(dec_valid), .ucode_req(ucode_req), .q_stall(q_stall)
    );

    typedef struct packed {
        logic [1:0] v;
        logic [3:0] l0; logic [2:0] p0; logic x0; logic c0;
        logic [3:0] l1; logic [2:0] p1; logic x1; logic c1;
        logic [1:0] ed; logic eu;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{2'b11, 4'd3, 3'd0, 1'b0, 1'b0, 4'd4, 3'd1, 1'b0, 1'b0, 2'b11, 1'b0}, // R2 plain pair
        '{2'b11, 4'd8, 3'd3, 1'b0, 1'b0, 4'd8, 3'd3, 1'b0, 1'b0, 2'b11, 1'b0}, // R3 R4 at limits
        '{2'b11, 4'd9, 3'd0, 1'b0, 1'b0, 4'd2, 3'd0, 1'b0, 1'b0, 2'b01, 1'b1}, // R3 long head
        '{2'b11, 4'd2, 3'd4, 1'b0, 1'b0, 4'd2, 3'd0, 1'b0, 1'b0, 2'b01, 1'b1}, // R4 prefixed head
        '{2'b11, 4'd1, 3'd0, 1'b0, 1'b1, 4'd2, 3'd0, 1'b0, 1'b0, 2'b01, 1'b1}, // R5 complex head
        '{2'b11, 4'd2, 3'd0, 1'b0, 1'b0, 4'd12,3'd0, 1'b0, 1'b0, 2'b01, 1'b0}, // R6 long slot 1
        '{2'b11, 4'd2, 3'd0, 1'b0, 1'b0, 4'd2, 3'd5, 1'b0, 1'b0, 2'b01, 1'b0}, // R6 prefixed slot 1
        '{2'b11, 4'd2, 3'd0, 1'b0, 1'b0, 4'd2, 3'd0, 1'b0, 1'b1, 2'b01, 1'b0}, // R6 complex slot 1
        '{2'b11, 4'd2, 3'd0, 1'b1, 1'b0, 4'd2, 3'd0, 1'b1, 1'b0, 2'b01, 1'b0}, // R8 two x87
        '{2'b11, 4'd2, 3'd0, 1'b1, 1'b0, 4'd2, 3'd0, 1'b0, 1'b0, 2'b11, 1'b0}, // R8 one x87 pairs
        '{2'b10, 4'd2, 3'd0, 1'b0, 1'b0, 4'd2, 3'd0, 1'b0, 1'b0, 2'b00, 1'b0}, // R9 no head
        '{2'b00, 4'd2, 3'd0, 1'b0, 1'b0, 4'd2, 3'd0, 1'b0, 1'b0, 2'b00, 1'b0}, // R2 empty
        '{2'b11, 4'd9, 3'd0, 1'b1, 1'b0, 4'd2, 3'd0, 1'b1, 1'b0, 2'b01, 1'b1}  // R10 uc with x87 pair
    };

    task automatic drive(input vec_t t);
        in_valid = t.v;
        s0_len = t.l0; s0_pfx = t.p0; s0_x87 = t.x0; s0_cplx = t.c0;
        s1_len = t.l1; s1_pfx = t.p1; s1_x87 = t.x1; s1_cplx = t.c1;
    endtask

    task automatic plain_pair();
        drive('{2'b11, 4'd3, 3'd0, 1'b0, 1'b0, 4'd3, 3'd0, 1'b0, 1'b0, 2'b11, 1'b0});
    endtask

    task automatic chk(input string tag, input logic [1:0] ed, input logic eu, input logic es);
        total++;
        if (dec_valid !== ed || ucode_req !== eu || q_stall !== es) begin
            bad++;
            $display("FAIL %s: got dec=%b uc=%b stall=%b, want dec=%b uc=%b stall=%b",
                     tag, dec_valid, ucode_req, q_stall, ed, eu, es);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        total++; bad++;
        $display("FAIL watchdog: got timeout, want completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        plain_pair();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first cycle after reset", 2'b11, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(posedge clk); #1 drive(VT[i]);
            @(negedge clk);
            chk($sformatf("vector %0d", i), VT[i].ed, VT[i].eu, 1'b0);
            if (VT[i].eu) begin
                for (int k = 0; k < 2; k++) begin
                    @(posedge clk); #1 plain_pair();
                    @(negedge clk);
                    chk($sformatf("R7 delay cycle %0d after vector %0d", k, i), 2'b00, 1'b0, 1'b1);
                end
                @(posedge clk); #1 plain_pair();
                @(negedge clk);
                chk($sformatf("R7 resume after vector %0d", i), 2'b11, 1'b0, 1'b0);
            end
        end

        // R6: held slot 1 shifts to slot 0 and then starts the transfer itself
        @(posedge clk); #1 drive('{2'b11, 4'd2, 3'd0, 1'b0, 1'b0, 4'd10, 3'd0, 1'b0, 1'b0, 2'b01, 1'b0});
        @(negedge clk);
        chk("R6 hold younger", 2'b01, 1'b0, 1'b0);
        @(posedge clk); #1 drive('{2'b01, 4'd10, 3'd0, 1'b0, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 2'b01, 1'b1});
        @(negedge clk);
        chk("R6 reissued in slot 0", 2'b01, 1'b1, 1'b0);

        // R1: reset in the middle of the delay clears it
        @(posedge clk); #1 begin plain_pair(); rst_n = 1'b0; end
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset cancels delay", 2'b11, 1'b0, 1'b0);

        // R5: complex flag with small length and no prefixes still goes to microcode
        @(posedge clk); #1 drive('{2'b01, 4'd1, 3'd0, 1'b1, 1'b1, 4'd0, 3'd0, 1'b0, 1'b0, 2'b01, 1'b1});
        @(negedge clk);
        chk("R5 complex x87 head", 2'b01, 1'b1, 1'b0);
        @(posedge clk); #1 in_valid = 2'b00;
        @(negedge clk);
        chk("R7 stall with idle queue", 2'b00, 1'b0, 1'b1);

        finish_run();
    end
endmodule